// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block collects every request that can reset the chip and turns them into one system reset output. Power-on, a debounced external reset pin, a watchdog timeout and a loss-of-clock condition from the clock generator can all start a reset. The sources fall into two groups. Loss-of-clock is treated as catastrophic and resets the system on the next clock edge. The external pin and the watchdog are deferred: if a bus cycle is in flight, the reset waits until that cycle ends. During that wait the bus monitor is forced on, so a cycle that never completes is cut off by a timeout.

Once a reset has begun, the output stays asserted while the release conditions are false. Those conditions are: supply good, PLL locked when the PLL clock mode is selected, and the external pin negated. After the conditions hold, a fixed 512-cycle stretch follows before the system is released. A new watchdog or loss-of-clock request during the stretch starts it again from zero. A one-hot cause register reports the source of the most recent reset. Only power-on returns it to the power-on code.

The same bus monitor also serves normal operation. When its software enable is set, it terminates any bus cycle that runs longer than a programmable limit.

Top module: `sysrst_hub`

## Requirements
- R1: While `rst` is high, and afterwards until `supply_ok_i` is sampled high, `sys_rst_o` is 1. With `pll_mode_i` high, it also stays 1 until `pll_lock_i` is sampled high.
- R2: Call the first rising edge at which the release conditions (supply good, lock if in PLL mode, `ext_rst_n_i` high) are sampled true edge g. `sys_rst_o` stays 1 through edge g+511 and is 0 after edge g+512.
- R3: The external pin is recognized only when `ext_rst_n_i` is sampled low on 4 consecutive rising edges. With the bus idle, `sys_rst_o` is 1 after the 4th such edge. Three low edges have no effect on `sys_rst_o` or `cause_o`.
- R4: A pin or watchdog request made while `bus_active_i` is high leaves `sys_rst_o` at 0 and drives `bm_force_o` to 1 until the bus cycle ends. `sys_rst_o` is 1 after the edge at which `bus_done_i` is sampled high.
- R5: While a deferred reset waits, the monitor counts bus-active cycles even with `bm_en_i` low. After 64<<`bm_sel_i` such cycles, `bm_term_o` is high for one cycle, and `sys_rst_o` is 1 after the following edge.
- R6: With `pll_mode_i` and `loc_en_i` both high, `pll_ref_fail_i` high or `pll_lock_i` low puts `sys_rst_o` at 1 after the next edge, even while a bus cycle is active.
- R7: Loss-of-clock conditions have no effect when `pll_mode_i` is low or `loc_en_i` is low: `sys_rst_o` stays 0 and `cause_o` is unchanged.
- R8: For a pin reset, the 512-cycle stretch starts only after `ext_rst_n_i` has returned high.
- R9: `cause_o` is one-hot with bit 0 power-on, bit 1 external pin, bit 2 watchdog, bit 3 loss-of-clock. It holds the most recent source, and only `rst` sets it back to bit 0.
- R10: A watchdog or loss-of-clock request sampled during the stretch restarts it. `sys_rst_o` is then 0 only after 512 further edges.
- R11: In normal operation with `bm_en_i` high, a bus cycle that stays active for 64<<`bm_sel_i` cycles gets a one-cycle `bm_term_o` pulse. With `bm_en_i` low, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| supply_ok_i | input | 1 | Supply has reached its minimum level |
| pll_mode_i | input | 1 | PLL clock mode selected |
| pll_lock_i | input | 1 | PLL is locked |
| pll_ref_fail_i | input | 1 | PLL reference clock has failed |
| loc_en_i | input | 1 | Enable for the loss-of-clock reset |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdog_to_i | input | 1 | Watchdog timeout pulse |
| bus_active_i | input | 1 | A bus cycle is in progress |
| bus_done_i | input | 1 | The bus cycle is terminating normally |
| bm_en_i | input | 1 | Software enable for the bus monitor |
| bm_sel_i | input | 2 | Monitor limit select: 64, 128, 256 or 512 cycles |
| sys_rst_o | output | 1 | System reset, active high |
| bm_force_o | output | 1 | Bus monitor forced on while a reset is deferred |
| bm_term_o | output | 1 | One-cycle forced termination of the bus cycle |
| cause_o | output | 4 | One-hot cause of the most recent reset |

## Verification
The bench aims at the edges of the counting windows. It checks a pin pulse one edge short of recognition, the exact cycle of release after the 512-cycle stretch, and the exact cycle in which the forced timeout fires. An off-by-one filter would reset on glitches or miss a valid pin reset. A stretch counter that is wrong by one would release a cycle early or late, and the bench would see that at the exact sampling point. It also checks a deferred reset against a bus cycle that never completes: a design that forgot to force the monitor would hang there forever. It applies loss-of-clock during an active bus cycle, so a design that waited for the cycle would show no reset. A watchdog request in the middle of the stretch checks that the count restarts instead of carrying on.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DEFER   = 2'd1,
        ST_HOLD    = 2'd2,
        ST_STRETCH = 2'd3
    } rst_state_t;

    typedef struct packed {
        logic loc;
        logic wdog;
        logic ext;
        logic por;
    } cause_t;

    localparam cause_t CAUSE_POR  = '{loc: 1'b0, wdog: 1'b0, ext: 1'b0, por: 1'b1};
    localparam cause_t CAUSE_EXT  = '{loc: 1'b0, wdog: 1'b0, ext: 1'b1, por: 1'b0};
    localparam cause_t CAUSE_WDOG = '{loc: 1'b0, wdog: 1'b1, ext: 1'b0, por: 1'b0};
    localparam cause_t CAUSE_LOC  = '{loc: 1'b1, wdog: 1'b0, ext: 1'b0, por: 1'b0};

    function automatic int unsigned bm_cycles(input int unsigned base, input logic [1:0] sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic hit_o
);
    localparam int unsigned W = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (pin_n_i) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit_o = !pin_n_i && (run_q == LAST);
endmodule

// File: rtl/sysrst_bus_watch.sv
module sysrst_bus_watch #(
    parameter int unsigned BASE = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       bus_active_i,
    input  logic       bus_done_i,
    input  logic [1:0] sel_i,
    output logic       term_o
);
    import sysrst_pkg::*;

    localparam int unsigned CW = $clog2(BASE) + 3;

    logic [CW-1:0] age_q;
    logic [CW-1:0] last;
    logic          live;

    assign last   = CW'(bm_cycles(BASE, sel_i) - 1);
    assign live   = en_i && bus_active_i && !bus_done_i;
    assign term_o = live && (age_q == last);

    always_ff @(posedge clk) begin
        if (rst || !live || term_o) begin
            age_q <= '0;
        end else begin
            age_q <= age_q + 1'b1;
        end
    end
endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
    parameter int unsigned LEN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic done_o
);
    localparam int unsigned W = $clog2(LEN);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] span_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            span_q <= '0;
        end else if (span_q != LAST) begin
            span_q <= span_q + 1'b1;
        end
    end

    assign done_o = (span_q == LAST);
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub #(
    parameter int unsigned STRETCH_LEN = 512,
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned BM_BASE     = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_i,
    input  logic       pll_mode_i,
    input  logic       pll_lock_i,
    input  logic       pll_ref_fail_i,
    input  logic       loc_en_i,
    input  logic       ext_rst_n_i,
    input  logic       wdog_to_i,
    input  logic       bus_active_i,
    input  logic       bus_done_i,
    input  logic       bm_en_i,
    input  logic [1:0] bm_sel_i,
    output logic       sys_rst_o,
    output logic       bm_force_o,
    output logic       bm_term_o,
    output logic [3:0] cause_o
);
    import sysrst_pkg::*;

    rst_state_t state_q, state_d;
    cause_t     cause_q;

    logic ext_hit;
    logic loc_evt;
    logic sync_req;
    logic gate_ok;
    logic restart;
    logic span_clr;
    logic span_done;
    logic watch_en;

    sysrst_pin_filter #(.LEN(FILT_LEN)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .pin_n_i (ext_rst_n_i),
        .hit_o   (ext_hit)
    );

    assign loc_evt  = pll_mode_i && loc_en_i && (pll_ref_fail_i || !pll_lock_i);
    assign sync_req = wdog_to_i || ext_hit;
    assign gate_ok  = supply_ok_i && (!pll_mode_i || pll_lock_i) && ext_rst_n_i;
    assign restart  = (state_q == ST_STRETCH) && (wdog_to_i || loc_evt);
    assign span_clr = (state_q != ST_STRETCH) || restart;
    assign watch_en = (state_q == ST_DEFER) || ((state_q == ST_RUN) && bm_en_i);

    sysrst_stretch #(.LEN(STRETCH_LEN)) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (span_clr),
        .done_o (span_done)
    );

    sysrst_bus_watch #(.BASE(BM_BASE)) u_watch (
        .clk          (clk),
        .rst          (rst),
        .en_i         (watch_en),
        .bus_active_i (bus_active_i),
        .bus_done_i   (bus_done_i),
        .sel_i        (bm_sel_i),
        .term_o       (bm_term_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (loc_evt) begin
                    state_d = ST_HOLD;
                end else if (sync_req) begin
                    state_d = bus_active_i ? ST_DEFER : ST_HOLD;
                end
            end
            ST_DEFER: begin
                if (loc_evt || bus_done_i || bm_term_o || !bus_active_i) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (gate_ok) begin
                    state_d = ST_STRETCH;
                end
            end
            ST_STRETCH: begin
                if (!gate_ok) begin
                    state_d = ST_HOLD;
                end else if (!restart && span_done) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            cause_q <= CAUSE_POR;
        end else begin
            state_q <= state_d;
            if (loc_evt && (state_q != ST_HOLD)) begin
                cause_q <= CAUSE_LOC;
            end else if (wdog_to_i) begin
                cause_q <= CAUSE_WDOG;
            end else if (ext_hit) begin
                cause_q <= CAUSE_EXT;
            end
        end
    end

    assign sys_rst_o  = (state_q == ST_HOLD) || (state_q == ST_STRETCH);
    assign bm_force_o = (state_q == ST_DEFER);
    assign cause_o    = cause_q;
endmodule

// File: rtl/sysrst_hub_chk.sv
module sysrst_hub_chk (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok_i,
    input logic       pll_mode_i,
    input logic       pll_lock_i,
    input logic       pll_ref_fail_i,
    input logic       loc_en_i,
    input logic       ext_rst_n_i,
    input logic       bus_active_i,
    input logic       bus_done_i,
    input logic       sys_rst_o,
    input logic       bm_force_o,
    input logic       bm_term_o,
    input logic [3:0] cause_o
);
    logic loc_now;
    assign loc_now = pll_mode_i && loc_en_i && (pll_ref_fail_i || !pll_lock_i);

    // R6: loss-of-clock outside reset resets on the next edge
    p_async_next_r6: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst_o && loc_now) |=> sys_rst_o);

    // R4: a deferred reset holds off while the bus cycle is still running
    p_defer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bm_force_o && bus_active_i && !bus_done_i && !bm_term_o && !loc_now) |=> !sys_rst_o);

    // R4: the monitor is only forced while reset is not yet asserted
    p_force_excl_r4: assert property (@(posedge clk) disable iff (rst)
        bm_force_o |-> !sys_rst_o);

    // R2: release only after supply good and pin negated were sampled
    p_release_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> $past(supply_ok_i && ext_rst_n_i));

    // R5: a forced terminate needs a live bus cycle and is a single pulse
    p_term_live_r5: assert property (@(posedge clk) disable iff (rst)
        bm_term_o |-> (bus_active_i && !bus_done_i && !sys_rst_o));
    p_term_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        bm_term_o |=> !bm_term_o);

    // R9: cause register always one-hot
    p_cause_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(cause_o) == 1);
endmodule

bind sysrst_hub sysrst_hub_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .supply_ok_i    (supply_ok_i),
    .pll_mode_i     (pll_mode_i),
    .pll_lock_i     (pll_lock_i),
    .pll_ref_fail_i (pll_ref_fail_i),
    .loc_en_i       (loc_en_i),
    .ext_rst_n_i    (ext_rst_n_i),
    .bus_active_i   (bus_active_i),
    .bus_done_i     (bus_done_i),
    .sys_rst_o      (sys_rst_o),
    .bm_force_o     (bm_force_o),
    .bm_term_o      (bm_term_o),
    .cause_o        (cause_o)
);

// File: tb/sysrst_hub_tb_top.sv
module sysrst_hub_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok_i = 1'b1;
    logic       pll_mode_i = 1'b0;
    logic       pll_lock_i = 1'b1;
    logic       pll_ref_fail_i = 1'b0;
    logic       loc_en_i = 1'b0;
    logic       ext_rst_n_i = 1'b1;
    logic       wdog_to_i = 1'b0;
    logic       bus_active_i = 1'b0;
    logic       bus_done_i = 1'b0;
    logic       bm_en_i = 1'b0;
    logic [1:0] bm_sel_i = 2'd0;
    logic       sys_rst_o;
    logic       bm_force_o;
    logic       bm_term_o;
    logic [3:0] cause_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sysrst_hub dut_i (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i), .pll_mode_i(pll_mode_i),
        .pll_lock_i(pll_lock_i), .pll_ref_fail_i(pll_ref_fail_i), .loc_en_i(loc_en_i),
        .ext_rst_n_i(ext_rst_n_i), .wdog_to_i(wdog_to_i), .bus_active_i(bus_active_i),
        .bus_done_i(bus_done_i), .bm_en_i(bm_en_i), .bm_sel_i(bm_sel_i),
        .sys_rst_o(sys_rst_o), .bm_force_o(bm_force_o), .bm_term_o(bm_term_o),
        .cause_o(cause_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_release();
        int n = 0;
        while (sys_rst_o && n < 2000) begin
            tick(1);
            n++;
        end
        chk("R2", "reset released", int'(sys_rst_o), 0);
    endtask

    task automatic t_power_on();
        rst = 1'b1; supply_ok_i = 1'b0;
        tick(3);
        chk("R1", "reset during rst", int'(sys_rst_o), 1);
        chk("R9", "cause after rst", int'(cause_o), 1);
        chk("R4", "force during rst", int'(bm_force_o), 0);
        rst = 1'b0;
        tick(50);
        chk("R1", "held without supply", int'(sys_rst_o), 1);
        supply_ok_i = 1'b1;
        tick(512);
        chk("R2", "still held at g+511", int'(sys_rst_o), 1);
        tick(1);
        chk("R2", "released at g+512", int'(sys_rst_o), 0);
    endtask

    task automatic t_pll_power_on();
        pll_mode_i = 1'b1; pll_lock_i = 1'b0; rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(700);
        chk("R1", "held until lock", int'(sys_rst_o), 1);
        pll_lock_i = 1'b1;
        tick(512);
        chk("R2", "pll still held at g+511", int'(sys_rst_o), 1);
        tick(1);
        chk("R2", "pll released at g+512", int'(sys_rst_o), 0);
        chk("R9", "cause stays power-on", int'(cause_o), 1);
        pll_mode_i = 1'b0;
    endtask

    task automatic t_ext_short();
        ext_rst_n_i = 1'b0;
        tick(3);
        ext_rst_n_i = 1'b1;
        tick(10);
        chk("R3", "three low edges ignored", int'(sys_rst_o), 0);
        chk("R3", "cause unchanged", int'(cause_o), 1);
    endtask

    task automatic t_ext_long();
        ext_rst_n_i = 1'b0;
        tick(4);
        chk("R3", "reset after 4th edge", int'(sys_rst_o), 1);
        chk("R9", "cause external", int'(cause_o), 2);
        tick(20);
        chk("R8", "held while pin low", int'(sys_rst_o), 1);
        ext_rst_n_i = 1'b1;
        tick(512);
        chk("R8", "stretch counted after pin high", int'(sys_rst_o), 1);
        tick(1);
        chk("R8", "released 512 after pin high", int'(sys_rst_o), 0);
    endtask

    task automatic t_ext_defer();
        bus_active_i = 1'b1;
        ext_rst_n_i = 1'b0;
        tick(4);
        ext_rst_n_i = 1'b1;
        chk("R4", "deferred: reset low", int'(sys_rst_o), 0);
        chk("R4", "deferred: monitor forced", int'(bm_force_o), 1);
        tick(10);
        chk("R4", "still deferred", int'(sys_rst_o), 0);
        bus_done_i = 1'b1;
        tick(1);
        bus_done_i = 1'b0; bus_active_i = 1'b0;
        chk("R4", "reset after bus done", int'(sys_rst_o), 1);
        chk("R4", "force dropped", int'(bm_force_o), 0);
        wait_release();
    endtask

    task automatic t_wdog_timeout();
        bus_active_i = 1'b1; bm_en_i = 1'b0; bm_sel_i = 2'd0;
        wdog_to_i = 1'b1;
        tick(1);
        wdog_to_i = 1'b0;
        chk("R4", "wdog deferred", int'(sys_rst_o), 0);
        chk("R9", "cause watchdog", int'(cause_o), 4);
        tick(62);
        chk("R5", "no terminate before limit", int'(bm_term_o), 0);
        tick(1);
        chk("R5", "terminate at 64", int'(bm_term_o), 1);
        chk("R5", "reset not yet", int'(sys_rst_o), 0);
        tick(1);
        chk("R5", "reset after terminate", int'(sys_rst_o), 1);
        bus_active_i = 1'b0;
        wait_release();
    endtask

    task automatic t_loc_restart();
        pll_mode_i = 1'b1; loc_en_i = 1'b1; pll_lock_i = 1'b1; bus_active_i = 1'b1;
        pll_ref_fail_i = 1'b1;
        tick(1);
        pll_ref_fail_i = 1'b0;
        chk("R6", "immediate reset on loss of clock", int'(sys_rst_o), 1);
        chk("R6", "no deferral", int'(bm_force_o), 0);
        chk("R9", "cause loss of clock", int'(cause_o), 8);
        tick(200);
        wdog_to_i = 1'b1;
        tick(1);
        wdog_to_i = 1'b0;
        tick(511);
        chk("R10", "restarted stretch still held", int'(sys_rst_o), 1);
        chk("R10", "cause watchdog after restart", int'(cause_o), 4);
        tick(1);
        chk("R10", "released 512 after restart", int'(sys_rst_o), 0);
        bus_active_i = 1'b0;
    endtask

    task automatic t_loc_off();
        pll_mode_i = 1'b0; loc_en_i = 1'b1; pll_ref_fail_i = 1'b1;
        tick(20);
        chk("R7", "ignored outside pll mode", int'(sys_rst_o), 0);
        pll_mode_i = 1'b1; loc_en_i = 1'b0; pll_lock_i = 1'b0;
        tick(20);
        chk("R7", "ignored with enable low", int'(sys_rst_o), 0);
        chk("R7", "cause unchanged", int'(cause_o), 4);
        pll_lock_i = 1'b1; pll_ref_fail_i = 1'b0; pll_mode_i = 1'b0;
    endtask

    task automatic t_monitor();
        int pulses = 0;
        bm_en_i = 1'b1; bm_sel_i = 2'd1; bus_active_i = 1'b1;
        tick(126);
        chk("R11", "no pulse at 126", int'(bm_term_o), 0);
        tick(1);
        chk("R11", "pulse at 128 limit", int'(bm_term_o), 1);
        tick(1);
        chk("R11", "pulse is one cycle", int'(bm_term_o), 0);
        chk("R11", "monitor does not reset", int'(sys_rst_o), 0);
        bm_en_i = 1'b0;
        for (int i = 0; i < 600; i++) begin
            tick(1);
            if (bm_term_o) pulses++;
        end
        chk("R11", "no pulse when disabled", pulses, 0);
        bus_active_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_power_on();
        t_pll_power_on();
        t_ext_short();
        t_ext_long();
        t_ext_defer();
        t_wdog_timeout();
        t_loc_restart();
        t_loc_off();
        t_monitor();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule